// File: doc/BRIEF.md
# Stepper Micro-Step Angle Sequencer

This block keeps track of the electrical angle of a two-phase stepper motor and converts it into per-phase current commands for a downstream current regulator. Each rising edge of a step input moves the angle forwards or backwards. The step input is sampled on the system clock. The amount each step moves the angle depends on the selected excitation mode. For each phase the block outputs a 4-bit magnitude code, a polarity bit and a torque-scaled current reference in percent. A monitor output marks the home position of the motor.

The angle is held as a 6-bit count of sixteenth-steps, so one electrical revolution is 64 counts. Coarser modes move the count by larger increments. A new excitation mode on the mode input does not take effect at once. It is held until the angle is back at the home position of the running mode, so a mode change never happens partway through a revolution. A synchronous rezero input applies a mode immediately and loads that mode's start angle. A standby input and the low-power mode code both silence the current outputs. Neither one disturbs the angle.

Top module: `stepper_angle_seq`

## Requirements
- R1: The angle advances once per rising edge of `step_clk`, detected on `clk`. The step size per edge depends on `mode_sel`: 111 → 1 count, 110 → 2, 101 → 4, 011 and 100 → 8, 010 → 16. One revolution therefore takes 64, 32, 16, 8 or 8, and 4 step edges, and `at_zero` returns high after exactly that many edges.
- R2: When `dir_fwd` is 1 the angle count is incremented (modulo 64) on a step. When it is 0 the count is decremented.
- R3: Phase A follows a sine and phase B follows a cosine of the angle. For phase A, take the angle p; for phase B, take p+16, modulo 64. Let k = that value mod 32. The table index is k when k ≤ 16, otherwise 32−k. The magnitude code is the index, clamped to 15. Codes 0..15 stand for 0,10,20,29,38,47,56,63,71,77,83,88,92,96,98,100 percent.
- R4: `pol_a` is 1 for angle counts 0..31 and 0 for 32..63. `pol_b` is 1 for counts 0..15 and 48..63 and 0 for 16..47.
- R5: `at_zero` is high exactly when the angle count equals the home position of the active mode. The home position is count 8 (45 degrees) in two-phase mode (010) and count 0 in every other mode. At count 0, phase B is at code 15 and phase A is at code 0.
- R6: In two-phase mode (010) both magnitude codes are 15. In half-step type B (100), both codes are 15 whenever angle bit 3 is set. Half-step type A (011) uses the plain table of R3.
- R7: In motor-lock mode (001) step edges are ignored and the angle stays at count 0.
- R8: The mode input is registered on every clock. A registered value that differs from the active mode becomes active only on a cycle in which the angle equals the active home and no step edge occurs. On that cycle the angle is loaded with the home position of the new mode.
- R9: While `rezero` is high at a clock edge, `mode_sel` becomes the active mode at once and the angle is loaded with that mode's home position. After rezero into two-phase mode, both codes are 15 and `at_zero` is 1.
- R10: In low-power mode (000) the angle still advances by 1 count per step edge, but both codes and both references are 0.
- R11: While `standby` is 1, both codes and both references are 0. Step edges still move the angle, and the outputs resume from the tracked angle when `standby` returns to 0.
- R12: Each reference equals floor(pct × T / 100). Here pct is the percent for the phase's code, and T depends on `torque_sel`: 11 → 100, 01 → 85, 10 → 70, 00 → 50.
- R13: An asynchronous low `rst_n` sets low-power mode and angle count 0. During and right after reset, the codes are 0 and `at_zero` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_clk | input | 1 | Step request; each rising edge moves the angle |
| dir_fwd | input | 1 | 1 = forward (count up), 0 = reverse |
| rezero | input | 1 | Synchronous: apply mode now, load start angle |
| standby | input | 1 | Silence both phase outputs |
| mode_sel | input | 3 | Requested excitation mode |
| torque_sel | input | 2 | Current reference scale |
| code_a | output | 4 | Phase A magnitude code |
| pol_a | output | 1 | Phase A polarity |
| iref_a | output | 7 | Phase A scaled reference, percent |
| code_b | output | 4 | Phase B magnitude code |
| pol_b | output | 1 | Phase B polarity |
| iref_b | output | 7 | Phase B scaled reference, percent |
| at_zero | output | 1 | High at the active mode's home position |

## Verification
A corrupted angle count or a wrong active mode shows on the code and polarity outputs in the first clock after the bad update, because those outputs are decoded directly from the state registers. A mode switch that is applied early, late or to the wrong start angle is only visible through the step increment that follows it. The bench therefore drives a step right after every deferred switch and compares the outputs every cycle. A stuck home detector causes a switch to be missed for a whole revolution, and the `at_zero` comparison catches that on the cycle the angle reaches home.

// File: rtl/stp_pkg.sv
package stp_pkg;

    localparam int FINE_W = 4;                 // sixteenth-steps per quadrant, log2
    localparam int QTR    = 1 << FINE_W;       // counts per quadrant
    localparam int ANG_W  = FINE_W + 2;        // four quadrants

    typedef logic [ANG_W-1:0] ang_t;

    typedef enum logic [2:0] {
        MD_LOWPWR    = 3'b000,
        MD_LOCK      = 3'b001,
        MD_FULL2     = 3'b010,
        MD_HALF_A    = 3'b011,
        MD_HALF_B    = 3'b100,
        MD_QTR       = 3'b101,
        MD_EIGHTH    = 3'b110,
        MD_SIXTEENTH = 3'b111
    } mode_e;

    typedef struct packed {
        mode_e act;
        mode_e pend;
        ang_t  ang;
        logic  step_prev;
    } ctrl_t;

    // counts moved per step edge
    function automatic ang_t step_inc(mode_e m);
        case (m)
            MD_LOWPWR:    return ang_t'(1);
            MD_LOCK:      return ang_t'(0);
            MD_FULL2:     return ang_t'(QTR);
            MD_HALF_A:    return ang_t'(QTR / 2);
            MD_HALF_B:    return ang_t'(QTR / 2);
            MD_QTR:       return ang_t'(QTR / 4);
            MD_EIGHTH:    return ang_t'(QTR / 8);
            default:      return ang_t'(1);
        endcase
    endfunction

    // start / home count of each mode
    function automatic ang_t home_pos(mode_e m);
        return (m == MD_FULL2) ? ang_t'(QTR / 2) : '0;
    endfunction

    // magnitude code to percent
    function automatic logic [6:0] code_pct(logic [3:0] c);
        case (c)
            4'd0:  return 7'd0;
            4'd1:  return 7'd10;
            4'd2:  return 7'd20;
            4'd3:  return 7'd29;
            4'd4:  return 7'd38;
            4'd5:  return 7'd47;
            4'd6:  return 7'd56;
            4'd7:  return 7'd63;
            4'd8:  return 7'd71;
            4'd9:  return 7'd77;
            4'd10: return 7'd83;
            4'd11: return 7'd88;
            4'd12: return 7'd92;
            4'd13: return 7'd96;
            4'd14: return 7'd98;
            default: return 7'd100;
        endcase
    endfunction

    function automatic logic [6:0] torque_pct(logic [1:0] t);
        case (t)
            2'b11:   return 7'd100;
            2'b01:   return 7'd85;
            2'b10:   return 7'd70;
            default: return 7'd50;
        endcase
    endfunction

endpackage

// File: rtl/stepper_angle_ctrl.sv
module stepper_angle_ctrl
    import stp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step_clk,
    input  logic       dir_fwd,
    input  logic       rezero,
    input  logic [2:0] mode_sel,
    output ang_t       ang,
    output mode_e      act_mode,
    output logic       stp_edge
);

    ctrl_t q, d;

    always_comb begin
        d           = q;
        stp_edge    = step_clk & ~q.step_prev;
        d.step_prev = step_clk;
        if (rezero) begin
            d.act  = mode_e'(mode_sel);
            d.pend = mode_e'(mode_sel);
            d.ang  = home_pos(mode_e'(mode_sel));
        end else begin
            d.pend = mode_e'(mode_sel);
            if (stp_edge) begin
                if (q.act != MD_LOCK) begin
                    d.ang = dir_fwd ? q.ang + step_inc(q.act)
                                    : q.ang - step_inc(q.act);
                end
            end else if (q.ang == home_pos(q.act) && q.pend != q.act) begin
                d.act = q.pend;
                d.ang = home_pos(q.pend);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{act: MD_LOWPWR, pend: MD_LOWPWR, ang: '0, step_prev: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign ang      = q.ang;
    assign act_mode = q.act;

endmodule

// File: rtl/stepper_phase_lut.sv
module stepper_phase_lut
    import stp_pkg::*;
#(
    parameter int OFFSET = 0,
    parameter int CODE_W = 4
) (
    input  ang_t              ang,
    input  mode_e             act_mode,
    output logic [CODE_W-1:0] code,
    output logic              pol
);

    localparam int IDX_W = FINE_W + 1;
    localparam logic [CODE_W-1:0] FULL = {CODE_W{1'b1}};

    ang_t              pos;
    logic [IDX_W-1:0]  idx;
    logic [CODE_W-1:0] base;

    always_comb begin
        pos  = ang + ang_t'(OFFSET);
        idx  = pos[FINE_W] ? (IDX_W'(QTR) - IDX_W'(pos[FINE_W-1:0]))
                           : IDX_W'(pos[FINE_W-1:0]);
        base = idx[FINE_W] ? FULL : CODE_W'(idx[FINE_W-1:0]);
        pol  = ~pos[ANG_W-1];
        case (act_mode)
            MD_FULL2:  code = FULL;
            MD_HALF_B: code = ang[FINE_W-1] ? FULL : base;
            default:   code = base;
        endcase
    end

endmodule

// File: rtl/stepper_torque_scale.sv
module stepper_torque_scale
    import stp_pkg::*;
#(
    parameter int CODE_W = 4,
    parameter int PCT_W  = 7
) (
    input  logic [CODE_W-1:0] code_in,
    input  logic [1:0]        torque_sel,
    input  logic              force_off,
    output logic [CODE_W-1:0] code_out,
    output logic [PCT_W-1:0]  iref
);

    localparam int PROD_W = 2 * PCT_W;

    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] quo;

    always_comb begin
        prod = PROD_W'(code_pct(4'(code_in))) * PROD_W'(torque_pct(torque_sel));
        quo  = prod / PROD_W'(100);
        if (force_off) begin
            code_out = '0;
            iref     = '0;
        end else begin
            code_out = code_in;
            iref     = quo[PCT_W-1:0];
        end
    end

endmodule

// File: rtl/stepper_angle_seq.sv
module stepper_angle_seq
    import stp_pkg::*;
#(
    parameter int CODE_W = 4,
    parameter int PCT_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_clk,
    input  logic              dir_fwd,
    input  logic              rezero,
    input  logic              standby,
    input  logic [2:0]        mode_sel,
    input  logic [1:0]        torque_sel,
    output logic [CODE_W-1:0] code_a,
    output logic              pol_a,
    output logic [PCT_W-1:0]  iref_a,
    output logic [CODE_W-1:0] code_b,
    output logic              pol_b,
    output logic [PCT_W-1:0]  iref_b,
    output logic              at_zero
);

    localparam int NPH = 2;

    ang_t              ang_w;
    mode_e             act_w;
    logic              edge_w;
    logic              off_w;
    logic [CODE_W-1:0] raw_code [NPH];
    logic              raw_pol  [NPH];
    logic [CODE_W-1:0] out_code [NPH];
    logic [PCT_W-1:0]  out_ref  [NPH];

    stepper_angle_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_clk (step_clk),
        .dir_fwd  (dir_fwd),
        .rezero   (rezero),
        .mode_sel (mode_sel),
        .ang      (ang_w),
        .act_mode (act_w),
        .stp_edge (edge_w)
    );

    assign off_w = standby | (act_w == MD_LOWPWR);

    // phase 0 = A (sine), phase 1 = B (quarter-turn ahead)
    for (genvar ph = 0; ph < NPH; ph++) begin : g_phase
        stepper_phase_lut #(.OFFSET(ph * QTR), .CODE_W(CODE_W)) u_lut (
            .ang      (ang_w),
            .act_mode (act_w),
            .code     (raw_code[ph]),
            .pol      (raw_pol[ph])
        );
        stepper_torque_scale #(.CODE_W(CODE_W), .PCT_W(PCT_W)) u_scale (
            .code_in    (raw_code[ph]),
            .torque_sel (torque_sel),
            .force_off  (off_w),
            .code_out   (out_code[ph]),
            .iref       (out_ref[ph])
        );
    end

    assign code_a  = out_code[0];
    assign pol_a   = raw_pol[0];
    assign iref_a  = out_ref[0];
    assign code_b  = out_code[1];
    assign pol_b   = raw_pol[1];
    assign iref_b  = out_ref[1];
    assign at_zero = (ang_w == home_pos(act_w));

endmodule

// File: rtl/stepper_angle_seq_chk.sv
module stepper_angle_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rezero,
    input logic       standby,
    input logic       stp_edge,
    input logic [5:0] ang,
    input logic [2:0] act,
    input logic [3:0] code_a,
    input logic [3:0] code_b,
    input logic [6:0] iref_a,
    input logic [6:0] iref_b,
    input logic       at_zero
);

    assert_fine_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (act == 3'b111 && stp_edge && !rezero) |=>
        (ang == $past(ang) + 6'd1 || ang == $past(ang) - 6'd1));

    assert_lock_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (act == 3'b001 && stp_edge && !rezero) |=> $stable(ang));

    assert_home_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (at_zero && !standby && act != 3'b000) |-> code_b == 4'd15);

    assert_rezero_home_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rezero |=> at_zero);

    assert_switch_home_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (act != $past(act)) |-> at_zero);

    assert_standby_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        standby |-> (code_a == 4'd0 && code_b == 4'd0 && iref_a == 7'd0 && iref_b == 7'd0));

    assert_ref_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (iref_a <= 7'd100 && iref_b <= 7'd100));

endmodule

bind stepper_angle_seq stepper_angle_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rezero   (rezero),
    .standby  (standby),
    .stp_edge (edge_w),
    .ang      (ang_w),
    .act      (act_w),
    .code_a   (code_a),
    .code_b   (code_b),
    .iref_a   (iref_a),
    .iref_b   (iref_b),
    .at_zero  (at_zero)
);

// File: tb/stepper_angle_seq_test.sv
`timescale 1ns/1ps
module stepper_angle_seq_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       step_clk = 1'b0;
    logic       dir_fwd = 1'b1;
    logic       rezero = 1'b0;
    logic       standby = 1'b0;
    logic [2:0] mode_sel = 3'b000;
    logic [1:0] torque_sel = 2'b11;
    logic [3:0] code_a, code_b;
    logic       pol_a, pol_b, at_zero;
    logic [6:0] iref_a, iref_b;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    stepper_angle_seq uut (
        .clk(clk), .rst_n(rst_n), .step_clk(step_clk), .dir_fwd(dir_fwd),
        .rezero(rezero), .standby(standby), .mode_sel(mode_sel),
        .torque_sel(torque_sel), .code_a(code_a), .pol_a(pol_a), .iref_a(iref_a),
        .code_b(code_b), .pol_b(pol_b), .iref_b(iref_b), .at_zero(at_zero)
    );

    // ---------------- reference model ----------------
    int pct_tab [16] = '{0,10,20,29,38,47,56,63,71,77,83,88,92,96,98,100};
    int m_act = 0, m_pend = 0, m_ang = 0;
    bit m_prev = 0;

    function automatic int stepsz(int m);
        case (m)
            0: return 1;  1: return 0;  2: return 16; 3: return 8;
            4: return 8;  5: return 4;  6: return 2;  default: return 1;
        endcase
    endfunction

    function automatic int homeof(int m);
        return (m == 2) ? 8 : 0;
    endfunction

    function automatic int tq(int t);
        case (t)
            3: return 100; 1: return 85; 2: return 70; default: return 50;
        endcase
    endfunction

    function automatic int e_code(int ph);
        int p, k, idx;
        if (standby || m_act == 0) return 0;
        if (m_act == 2) return 15;
        if (m_act == 4 && (m_ang % 16) == 8) return 15;
        p = (m_ang + 16 * ph) % 64;
        k = p % 32;
        idx = (k <= 16) ? k : 32 - k;
        return (idx > 15) ? 15 : idx;
    endfunction

    function automatic int e_pol(int ph);
        return (((m_ang + 16 * ph) % 64) < 32) ? 1 : 0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_act = 0; m_pend = 0; m_ang = 0; m_prev = 0;
        end else begin
            bit e;
            e = step_clk && !m_prev;
            m_prev = step_clk;
            if (rezero) begin
                m_act = mode_sel; m_pend = mode_sel; m_ang = homeof(mode_sel);
            end else begin
                if (e) begin
                    if (dir_fwd) m_ang = (m_ang + stepsz(m_act)) % 64;
                    else         m_ang = (m_ang + 64 - stepsz(m_act)) % 64;
                end else if (m_ang == homeof(m_act) && m_pend != m_act) begin
                    m_act = m_pend;
                    m_ang = homeof(m_pend);
                end
                m_pend = mode_sel;
            end
        end
    end

    task automatic chk(string req, int act_v, int exp_v);
        checks++;
        if (act_v != exp_v) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act_v, exp_v, $time);
        end
    endtask

    // every-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R3 code_a", code_a, e_code(0));
            chk("R3 code_b", code_b, e_code(1));
            chk("R4 pol_a", pol_a, e_pol(0));
            chk("R4 pol_b", pol_b, e_pol(1));
            chk("R12 iref_a", iref_a, pct_tab[e_code(0)] * tq(torque_sel) / 100);
            chk("R12 iref_b", iref_b, pct_tab[e_code(1)] * tq(torque_sel) / 100);
            chk("R5 at_zero", at_zero, (m_ang == homeof(m_act)) ? 1 : 0);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick(int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic pulse(int n);
        for (int i = 0; i < n; i++) begin
            step_clk = 1'b1; tick(1);
            step_clk = 1'b0; tick(1);
        end
    endtask

    task automatic do_rezero(int m);
        mode_sel = 3'(m); rezero = 1'b1; tick(1); rezero = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        int revs [6] = '{4, 8, 8, 16, 32, 64};
        tick(3);
        // R13: reset state
        chk("R13 at_zero", at_zero, 1);
        chk("R13 code_a", code_a, 0);
        chk("R13 code_b", code_b, 0);
        rst_n = 1'b1; tick(2);

        // R1/R2: sixteenth-step revolution, then reverse
        do_rezero(7);
        pulse(64);
        chk("R1 rev64 home", at_zero, 1);
        dir_fwd = 1'b0;
        pulse(10);                          // count 54
        chk("R2 reverse code_a", code_a, 10);
        chk("R2 reverse pol_a", pol_a, 0);

        // R8: deferred switch to eighth-step
        mode_sel = 3'b110; dir_fwd = 1'b1;
        tick(3);
        chk("R8 still old mode", code_a, 10);
        pulse(10);                          // back at 0, switch applied
        pulse(1);
        chk("R8 new step size", code_a, 2);

        // R1: revolution length per mode
        for (int i = 0; i < 6; i++) begin
            do_rezero(i + 2);
            pulse(revs[i] - 1);
            chk("R1 not yet home", at_zero, 0);
            pulse(1);
            chk("R1 home after rev", at_zero, 1);
        end

        // R9/R6: two-phase start and step
        do_rezero(2);
        chk("R9 two-phase a", code_a, 15);
        chk("R9 two-phase b", code_b, 15);
        chk("R9 two-phase home", at_zero, 1);
        pulse(1);
        chk("R6 two-phase a", code_a, 15);
        chk("R6 two-phase pol_b", pol_b, 0);

        // R6: half-step B diagonal, half-step A diagonal
        do_rezero(4); pulse(1);
        chk("R6 halfB a", code_a, 15);
        chk("R6 halfB b", code_b, 15);
        do_rezero(3); pulse(1);
        chk("R6 halfA a", code_a, 8);
        chk("R6 halfA iref", iref_a, 71);

        // R7: lock ignores steps
        do_rezero(1); pulse(5);
        chk("R7 lock home", at_zero, 1);
        chk("R7 lock b", code_b, 15);
        chk("R7 lock a", code_a, 0);

        // R10: low-power keeps counting
        do_rezero(0); pulse(3);
        chk("R10 lowpwr code", code_a, 0);
        chk("R10 lowpwr iref", iref_b, 0);
        mode_sel = 3'b111;
        pulse(61);
        pulse(1);
        chk("R10 angle tracked", code_a, 1);

        // R11: standby
        do_rezero(7); pulse(4);
        chk("R11 before", code_a, 4);
        standby = 1'b1; tick(1);
        chk("R11 silenced code", code_a, 0);
        chk("R11 silenced iref", iref_b, 0);
        pulse(2);
        standby = 1'b0; tick(1);
        chk("R11 resumed", code_a, 6);

        // R12: torque scaling at code 6 (56%)
        torque_sel = 2'b00; tick(1); chk("R12 t50", iref_a, 28);
        torque_sel = 2'b01; tick(1); chk("R12 t85", iref_a, 47);
        torque_sel = 2'b10; tick(1); chk("R12 t70", iref_a, 39);
        torque_sel = 2'b11; tick(1); chk("R12 t100", iref_a, 56);

        // R13: reset mid-run
        rst_n = 1'b0; #1;
        chk("R13 async home", at_zero, 1);
        chk("R13 async code", code_b, 0);
        tick(2);
        finish_run();
    end

endmodule